// File: doc/BRIEF.md
# Programmable Frame Sync Generator

This block generates one frame-synchronization waveform and fans it out to several camera links so that every link sees the same edge in the same clock cycle. A small byte-wide write port programs a control register, a 16-bit high duration, a 16-bit low duration, a time-base select and a per-port routing mask.

The generator counts in ticks rather than in raw clocks. One tick is one back-channel frame period, produced by a divider whose length is `CLKS_PER_UNIT * (sel + 1)` clock cycles. With the default of 75 clocks at 125 MHz, a tick lasts 600 ns, which matches a 30-bit frame at 50 Mbps. The control register chooses the source. It can run the internal generator, with either a forced 50/50 duty cycle or independent high and low times. It can instead pass one of eight external pins through, after synchronizing it and sampling it on the tick. Each port's output carries the chosen sync when that port is routed and stays low when it is not.

Top module: `fsync_gen_top`

## Requirements
- R1: After reset, `fsync` and every bit of `bc_gpio` are 0, and all registers hold 0.
- R2: With control bit 0 = 1 and bit 1 = 1, the waveform is high for H ticks and low for L ticks. H is {addr 2, addr 1} and L is {addr 4, addr 3}, each taken as a 16-bit value with the MSB byte at the higher address.
- R3: With control bit 0 = 1 and bit 1 = 0, both phases last H ticks, and the values at addresses 3 and 4 have no effect.
- R4: A programmed duration of 0 acts as a duration of 1 tick.
- R5: One tick is `CLKS_PER_UNIT * (sel + 1)` clocks, where `sel` is bits [2:0] written at address 5. Rising edges of the sync follow a tick by exactly one cycle.
- R6: When control bit 0 is cleared with the mode field below 8, `fsync` is 0 on the next clock. When the bit is set again, the waveform starts with a complete high phase.
- R7: With control bit 0 = 0 and control bits [7:4] = 8+g, `fsync` follows pin `gpio_in[g]`. The pin passes through a two-flop synchronizer and is sampled on each tick. The other pins have no effect.
- R8: With control bit 0 = 0 and control bits [7:4] below 8, `fsync` stays 0.
- R9: Bit p of the mask written at address 6 routes the sync to `bc_gpio[p]`. All routed ports change in the same cycle, and unrouted ports stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1/2 high LSB/MSB, 3/4 low LSB/MSB, 5 time base, 6 route mask) |
| wr_data | input | 8 | Register write data |
| gpio_in | input | 8 | Asynchronous external sync candidates |
| fsync | output | 1 | Selected frame sync, registered |
| bc_gpio | output | NPORT | Per-port routed frame sync, registered |

## Verification
The bench builds the block with `CLKS_PER_UNIT` = 2 and four ports. At that setting a tick is only a few clocks long, so tick counts of several hundred, including a duration that uses the upper byte, fit into short runs. The bench measures each phase length in clocks and compares it against the tick count multiplied by the divider length, for two time-base selects. It also covers enable toggling, the external pin selection and partial routing masks, all checked at the port outputs.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  localparam int ADDR_W = 3;
  localparam int NGPIO  = 8;
  localparam int DUR_W  = 16;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_HI_LSB = 3'd1;
  localparam logic [ADDR_W-1:0] A_HI_MSB = 3'd2;
  localparam logic [ADDR_W-1:0] A_LO_LSB = 3'd3;
  localparam logic [ADDR_W-1:0] A_LO_MSB = 3'd4;
  localparam logic [ADDR_W-1:0] A_TBASE  = 3'd5;
  localparam logic [ADDR_W-1:0] A_ROUTE  = 3'd6;

  typedef struct packed {
    logic [3:0] mode;   // >= 8 picks an external pin
    logic       split;  // 1: separate high/low, 0: 50/50
    logic       en;     // internal generator run
  } ctrl_t;
endpackage

// File: rtl/fsync_regs.sv
module fsync_regs
  import fsync_pkg::*;
#(
  parameter int NPORT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output ctrl_t             ctrl,
  output logic [DUR_W-1:0]  hi_len,
  output logic [DUR_W-1:0]  lo_len,
  output logic [2:0]        tsel,
  output logic [NPORT-1:0]  route
);
  logic [DUR_W-1:0] hi_raw, lo_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      hi_raw <= '0;
      lo_raw <= '0;
      tsel   <= '0;
      route  <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        A_CTRL:   ctrl   <= '{mode: wr_data[7:4], split: wr_data[1], en: wr_data[0]};
        A_HI_LSB: hi_raw[7:0]  <= wr_data;
        A_HI_MSB: hi_raw[15:8] <= wr_data;
        A_LO_LSB: lo_raw[7:0]  <= wr_data;
        A_LO_MSB: lo_raw[15:8] <= wr_data;
        A_TBASE:  tsel   <= wr_data[2:0];
        A_ROUTE:  route  <= wr_data[NPORT-1:0];
        default:  ;
      endcase
    end
  end

  // zero counts behave as one tick
  assign hi_len = (hi_raw == '0) ? DUR_W'(1) : hi_raw;
  assign lo_len = (lo_raw == '0) ? DUR_W'(1) : lo_raw;

  p_ctrl_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_CTRL) |=> (ctrl.en == $past(wr_data[0]) && ctrl.mode == $past(wr_data[7:4])));
  p_nonzero_len_r4: assert property (@(posedge clk) disable iff (rst)
    (hi_len != '0) && (lo_len != '0));
endmodule

// File: rtl/fsync_tick.sv
module fsync_tick #(
  parameter int CLKS_PER_UNIT = 75
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] tsel,
  output logic       tick
);
  localparam int CW = $clog2(CLKS_PER_UNIT * 8) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] period;

  assign period = CW'(CLKS_PER_UNIT) * (CW'(tsel) + CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= period - CW'(1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + CW'(1);
      tick <= 1'b0;
    end
  end

  generate
    if (CLKS_PER_UNIT > 1) begin : g_chk
      p_tick_single_r5: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/fsync_wave.sv
module fsync_wave
  import fsync_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  ctrl_t            ctrl,
  input  logic [DUR_W-1:0] hi_len,
  input  logic [DUR_W-1:0] lo_len,
  input  logic [NGPIO-1:0] gpio_in,
  output logic             fsync
);
  localparam int GSW = $clog2(NGPIO);

  logic [NGPIO-1:0] sync1, sync2;
  logic             run, high_ph;
  logic [DUR_W-1:0] rem;
  logic [DUR_W-1:0] lo_eff;
  logic             ext;
  logic [GSW-1:0]   gsel;

  assign ext    = ctrl.mode[3];
  assign gsel   = ctrl.mode[GSW-1:0];
  assign lo_eff = ctrl.split ? lo_len : hi_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= gpio_in;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      high_ph <= 1'b0;
      rem     <= '0;
      fsync   <= 1'b0;
    end else if (ctrl.en) begin
      if (tick) begin
        if (!run) begin
          run     <= 1'b1;
          high_ph <= 1'b1;
          fsync   <= 1'b1;
          rem     <= hi_len - DUR_W'(1);
        end else if (rem == '0) begin
          high_ph <= !high_ph;
          fsync   <= !high_ph;
          rem     <= (high_ph ? lo_eff : hi_len) - DUR_W'(1);
        end else begin
          rem <= rem - DUR_W'(1);
        end
      end
    end else begin
      run     <= 1'b0;
      high_ph <= 1'b0;
      rem     <= '0;
      if (!ext)      fsync <= 1'b0;
      else if (tick) fsync <= sync2[gsel];
    end
  end

  p_rise_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(fsync) |-> $past(tick));
  p_idle_low_r8: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.en && !ext) |=> !fsync);
  p_stop_low_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(ctrl.en) && !ext) |=> !fsync);
endmodule

// File: rtl/fsync_gen_top.sv
module fsync_gen_top
  import fsync_pkg::*;
#(
  parameter int CLKS_PER_UNIT = 75,
  parameter int NPORT         = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [7:0]       gpio_in,
  output logic             fsync,
  output logic [NPORT-1:0] bc_gpio
);
  ctrl_t            ctrl;
  logic [DUR_W-1:0] hi_len, lo_len;
  logic [2:0]       tsel;
  logic [NPORT-1:0] route;
  logic             tick;

  fsync_regs #(.NPORT(NPORT)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl(ctrl), .hi_len(hi_len), .lo_len(lo_len), .tsel(tsel), .route(route)
  );

  fsync_tick #(.CLKS_PER_UNIT(CLKS_PER_UNIT)) u_tick (
    .clk(clk), .rst(rst), .tsel(tsel), .tick(tick)
  );

  fsync_wave u_wave (
    .clk(clk), .rst(rst), .tick(tick), .ctrl(ctrl), .hi_len(hi_len),
    .lo_len(lo_len), .gpio_in(gpio_in), .fsync(fsync)
  );

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      always_ff @(posedge clk) begin
        if (rst) bc_gpio[p] <= 1'b0;
        else     bc_gpio[p] <= route[p] & fsync;
      end
    end
  endgenerate

  p_ports_agree_r9: assert property (@(posedge clk) disable iff (rst)
    $stable(route) |-> (bc_gpio == '0 || bc_gpio == route));
endmodule

// File: tb/tb_fsync_gen_top.sv
module tb_fsync_gen_top;
  localparam int CPU   = 2;
  localparam int NPORT = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_addr = '0;
  logic [7:0]       wr_data = '0;
  logic [7:0]       gpio_in = '0;
  logic             fsync;
  logic [NPORT-1:0] bc_gpio;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  fsync_gen_top #(.CLKS_PER_UNIT(CPU), .NPORT(NPORT)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .gpio_in(gpio_in), .fsync(fsync), .bc_gpio(bc_gpio)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // waits for a rise on port 0, returns high then low length in clocks
  task automatic measure(output int hi_c, output int lo_c);
    int guard;
    hi_c = 0; lo_c = 0; guard = 0;
    while (bc_gpio[0] !== 1'b1 && guard < 3000) begin @(negedge clk); guard++; end
    while (bc_gpio[0] === 1'b1 && hi_c < 3000) begin hi_c++; @(negedge clk); end
    while (bc_gpio[0] !== 1'b1 && lo_c < 3000) begin lo_c++; @(negedge clk); end
  endtask

  task automatic set_dur(input int h, input int l);
    wr(3'd1, h[7:0]); wr(3'd2, h[15:8]);
    wr(3'd3, l[7:0]); wr(3'd4, l[15:8]);
  endtask

  task automatic t_reset;
    check("R1 fsync", fsync, 0);
    check("R1 bc_gpio", bc_gpio, 0);
    wr(3'd6, 8'h0F); idle(20);
    check("R1 idle with zero control", bc_gpio, 0);
  endtask

  task automatic t_split;
    int h, l;
    wr(3'd5, 8'd0);
    set_dur(3, 5);
    wr(3'd0, 8'h03);
    measure(h, l); measure(h, l);
    check("R2 high 3 ticks", h, 3 * CPU);
    check("R2 low 5 ticks", l, 5 * CPU);
    set_dur(16'h0102, 2);
    measure(h, l); measure(h, l);
    check("R2 16-bit high", h, 16'h0102 * CPU);
    check("R2 low 2 ticks", l, 2 * CPU);
  endtask

  task automatic t_fifty;
    int h, l;
    set_dur(3, 9);
    wr(3'd0, 8'h01);
    measure(h, l); measure(h, l);
    check("R3 high", h, 3 * CPU);
    check("R3 low ignores low reg", l, 3 * CPU);
  endtask

  task automatic t_zero;
    int h, l;
    set_dur(0, 0);
    wr(3'd0, 8'h03);
    measure(h, l); measure(h, l);
    check("R4 zero high", h, CPU);
    check("R4 zero low", l, CPU);
  endtask

  task automatic t_tbase;
    int h, l;
    wr(3'd5, 8'd2);
    set_dur(2, 1);
    measure(h, l); measure(h, l);
    check("R5 high with sel 2", h, 2 * 3 * CPU);
    check("R5 low with sel 2", l, 3 * CPU);
    wr(3'd5, 8'd0);
  endtask

  task automatic t_restart;
    int h, l;
    set_dur(6, 2);
    wr(3'd0, 8'h03);
    measure(h, l);
    idle(3);
    wr(3'd0, 8'h02);
    @(negedge clk);
    check("R6 fsync low after clear", fsync, 0);
    idle(20);
    check("R6 ports stay low", bc_gpio, 0);
    wr(3'd0, 8'h03);
    measure(h, l);
    check("R6 first high phase complete", h, 6 * CPU);
  endtask

  task automatic t_external;
    wr(3'd0, 8'hA0);
    gpio_in = 8'h04; idle(12);
    check("R7 pin 2 high", bc_gpio, 4'hF);
    gpio_in = 8'hFB; idle(12);
    check("R7 other pins ignored", bc_gpio, 0);
    gpio_in = 8'h80; wr(3'd0, 8'hF0); idle(12);
    check("R7 pin 7 high", fsync, 1);
    gpio_in = 8'h00; idle(12);
    check("R7 pin 7 low", fsync, 0);
    gpio_in = 8'hFF; wr(3'd0, 8'h70); idle(12);
    check("R8 mode below 8 stays low", bc_gpio, 0);
    gpio_in = 8'h00;
  endtask

  task automatic t_route;
    int h, l, bad;
    wr(3'd6, 8'h05);
    set_dur(2, 3);
    wr(3'd0, 8'h03);
    measure(h, l);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (bc_gpio[1] || bc_gpio[3] || (bc_gpio[2] != bc_gpio[0])) bad++;
    end
    check("R9 routed equal, unrouted low", bad, 0);
    check("R9 routed port toggles", h, 2 * CPU);
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_split;
    t_fifty;
    t_zero;
    t_tbase;
    t_restart;
    t_external;
    t_route;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule